// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter Stage

A synchronous up-counter slice, `W` bits wide (4 by default). It counts in plain binary and wraps from all ones back to zero. On a rising clock edge it can preset its state from a parallel data word. It has two count enables and a terminal-count flag, so several slices can be chained into one wider synchronous counter.

The first enable, `en_local`, only allows counting in this slice. The second, `en_chain`, also allows counting, and it additionally qualifies the terminal-count flag. To cascade slices, feed each slice's `term_out` into the `en_chain` input of the next slice. Drive every `en_local` from a common enable. The upper slices then advance exactly when all slices below them are at all ones.

The reset style is chosen when the block is built. With `ASYNC_RST = 1` an active-low reset clears the state at once, without waiting for the clock. With `ASYNC_RST = 0` the same pin clears the state on the next rising edge.

Top module: `bincnt_stage`

## Requirements
- R1: While counting, the state advances by one on each rising edge, and from all ones (15 at the default width) it goes to zero.
- R2: With `ASYNC_RST = 1`, a low `rst_n` drives `count` to zero at once, with no clock edge, and holds it there whatever the other inputs do.
- R3: With `ASYNC_RST = 0`, a low `rst_n` clears `count` to zero on the next rising edge, taking priority over both preset and counting.
- R4: When reset is inactive and `preset_n` is low, `preset_val` is copied into `count` on the next rising edge, whatever the values of `en_local` and `en_chain`.
- R5: When reset is inactive and `preset_n` is high, the state advances only when `en_local` and `en_chain` are both high. Otherwise it keeps its value.
- R6: `term_out` is high exactly when `count` is all ones and `en_chain` is high. Neither `preset_n` nor `en_local` affects it.
- R7: `term_out` is combinational: it responds to `en_chain` within the same cycle, without waiting for a clock edge.
- R8: Apart from the asynchronous reset, `count` changes only at a rising clock edge. An input change between edges leaves it as it was.
- R9: Two slices chained through `term_out` into `en_chain`, with a shared `en_local`, form an 8-bit counter that passes through 255 and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asynchronous or synchronous by `ASYNC_RST` |
| preset_n | input | 1 | Active-low parallel preset request |
| en_local | input | 1 | Count enable for this slice only |
| en_chain | input | 1 | Count enable that also qualifies `term_out` |
| preset_val | input | W | Value loaded on preset |
| count | output | W | Counter state |
| term_out | output | 1 | High when state is all ones and `en_chain` is high |

## Verification
The bound checker tests the following on every clock edge:
- the reset result for the selected style;
- the preset, increment and hold results that follow from the priority order;
- the two-way relation between `term_out`, `en_chain` and an all-ones state.

Some behaviour only the bench scenarios can show. These are the immediate clearing between edges, the stability of the synchronous slice between edges, and `term_out` responding before any edge. The scenarios also show that a two-slice chain carries correctly across 255. The bench also walks every combination of the four control inputs against a reference model.

// File: rtl/bincnt_pkg.sv
package bincnt_pkg;
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_PRESET = 2'd1,
        MODE_STEP = 2'd2,
        MODE_KEEP = 2'd3
    } mode_e;
endpackage

// File: rtl/bincnt_mode_sel.sv
// Priority decode of the control inputs: clear, then preset, then step, then keep.
module bincnt_mode_sel
    import bincnt_pkg::*;
(
    input  logic  clear_req,
    input  logic  preset_n,
    input  logic  en_local,
    input  logic  en_chain,
    output mode_e mode
);
    always_comb begin
        if (clear_req) begin
            mode = MODE_CLEAR;
        end else if (!preset_n) begin
            mode = MODE_PRESET;
        end else if (en_local && en_chain) begin
            mode = MODE_STEP;
        end else begin
            mode = MODE_KEEP;
        end
    end
endmodule

// File: rtl/bincnt_next.sv
// Next-state value for the selected mode.
module bincnt_next
    import bincnt_pkg::*;
#(
    parameter int W = 4
) (
    input  mode_e        mode,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] preset_val,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (mode)
            MODE_CLEAR:  nxt = '0;
            MODE_PRESET: nxt = preset_val;
            MODE_STEP:   nxt = cur + ONE;
            MODE_KEEP:   nxt = cur;
            default:     nxt = cur;
        endcase
    end
endmodule

// File: rtl/bincnt_term.sv
// Terminal-count flag: all ones, qualified by the chain enable only.
module bincnt_term #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         en_chain,
    output logic         term
);
    localparam logic [W-1:0] ALL_ONES = '1;

    always_comb begin
        term = en_chain && (cur == ALL_ONES);
    end
endmodule

// File: rtl/bincnt_stage.sv
module bincnt_stage
    import bincnt_pkg::*;
#(
    parameter int W = 4,
    parameter bit ASYNC_RST = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         preset_n,
    input  logic         en_local,
    input  logic         en_chain,
    input  logic [W-1:0] preset_val,
    output logic [W-1:0] count,
    output logic         term_out
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t state_d;
    state_t state_q;
    mode_e mode;
    logic clear_req;
    logic [W-1:0] cnt_nxt;

    // The asynchronous variant clears through the flop itself,
    // so only the synchronous variant feeds reset into the priority decode.
    generate
        if (ASYNC_RST) begin : g_async_clr
            assign clear_req = 1'b0;
        end else begin : g_sync_clr
            assign clear_req = !rst_n;
        end
    endgenerate

    bincnt_mode_sel u_mode (
        .clear_req (clear_req),
        .preset_n  (preset_n),
        .en_local  (en_local),
        .en_chain  (en_chain),
        .mode      (mode)
    );

    bincnt_next #(.W(W)) u_next (
        .mode       (mode),
        .cur        (state_q.cnt),
        .preset_val (preset_val),
        .nxt        (cnt_nxt)
    );

    always_comb begin
        state_d = state_q;
        state_d.cnt = cnt_nxt;
    end

    generate
        if (ASYNC_RST) begin : g_async_ff
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    state_q <= '0;
                end else begin
                    state_q <= state_d;
                end
            end
        end else begin : g_sync_ff
            always_ff @(posedge clk) begin
                state_q <= state_d;
            end
        end
    endgenerate

    bincnt_term #(.W(W)) u_term (
        .cur      (state_q.cnt),
        .en_chain (en_chain),
        .term     (term_out)
    );

    assign count = state_q.cnt;
endmodule

// File: rtl/bincnt_stage_chk.sv
module bincnt_stage_chk #(
    parameter int W = 4,
    parameter bit ASYNC_RST = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         preset_n,
    input logic         en_local,
    input logic         en_chain,
    input logic [W-1:0] preset_val,
    input logic [W-1:0] count,
    input logic         term_out
);
    generate
        if (ASYNC_RST) begin : g_async
            assert_async_clear_R2: assert property (@(posedge clk)
                !rst_n |-> count == '0);
        end else begin : g_sync
            assert_sync_clear_R3: assert property (@(posedge clk)
                !rst_n |=> count == '0);
        end
    endgenerate

    assert_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !preset_n |=> count == $past(preset_val));

    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && en_local && en_chain) |=> count == $past(count) + W'(1));

    assert_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && !(en_local && en_chain)) |=> $stable(count));

    assert_term_needs_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        term_out |-> (en_chain && (&count)));

    assert_term_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_chain && (&count)) |-> term_out);
endmodule

bind bincnt_stage bincnt_stage_chk #(.W(W), .ASYNC_RST(ASYNC_RST)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .preset_n   (preset_n),
    .en_local   (en_local),
    .en_chain   (en_chain),
    .preset_val (preset_val),
    .count      (count),
    .term_out   (term_out)
);

// File: tb/bincnt_stage_bench.sv
`timescale 1ns/1ps
module bincnt_stage_bench;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic preset_n = 1'b1;
    logic en_local = 1'b0;
    logic en_chain = 1'b0;
    logic [3:0] preset_val = '0;
    logic c_en = 1'b0;

    logic [3:0] q_a, q_s, q_c0, q_c1;
    logic tc_a, tc_s, tc_c0, tc_c1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] ma = '0, ms = '0;
    logic [7:0] mc = '0;
    bit ms_known = 1'b0;

    logic [3:0] qa_exp[$];
    logic [3:0] qs_exp[$];
    logic [7:0] qc_exp[$];
    string tag_q[$];

    always #(HALF) clk = ~clk;

    bincnt_stage u_bincnt_stage (
        .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .en_local(en_local),
        .en_chain(en_chain), .preset_val(preset_val), .count(q_a), .term_out(tc_a)
    );

    bincnt_stage #(.ASYNC_RST(1'b0)) u_sync (
        .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .en_local(en_local),
        .en_chain(en_chain), .preset_val(preset_val), .count(q_s), .term_out(tc_s)
    );

    bincnt_stage u_low (
        .clk(clk), .rst_n(rst_n), .preset_n(1'b1), .en_local(c_en),
        .en_chain(c_en), .preset_val(4'd0), .count(q_c0), .term_out(tc_c0)
    );

    bincnt_stage u_high (
        .clk(clk), .rst_n(rst_n), .preset_n(1'b1), .en_local(c_en),
        .en_chain(tc_c0), .preset_val(4'd0), .count(q_c1), .term_out(tc_c1)
    );

    function automatic logic [3:0] ref_next(input logic [3:0] cur, input logic r,
                                            input logic l, input logic p,
                                            input logic t, input logic [3:0] d);
        if (!r) return 4'd0;
        if (!l) return d;
        if (p && t) return cur + 4'd1;
        return cur;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of inputs, check the between-edge behaviour,
    // and queue the values expected after the coming edge.
    task automatic step(input logic r, input logic l, input logic p, input logic t,
                        input logic [3:0] d, input string tag);
        @(negedge clk);
        rst_n = r;
        preset_n = l;
        en_local = p;
        en_chain = t;
        preset_val = d;
        if (!r) begin
            ma = 4'd0;
            mc = 8'd0;
        end
        #1;
        check(tc_a == ((&ma) && t), "R6 R7", "term_out (async slice)", tc_a, (&ma) && t);
        if (ms_known)
            check(tc_s == ((&ms) && t), "R6 R7", "term_out (sync slice)", tc_s, (&ms) && t);
        if (!r)
            check(q_a == 4'd0, "R2", "count cleared before edge", q_a, 0);
        if (ms_known)
            check(q_s == ms, "R8", "sync count stable between edges", q_s, ms);
        ma = ref_next(ma, r, l, p, t, d);
        ms = ref_next(ms, r, l, p, t, d);
        if (!r) ms_known = 1'b1;
        if (r && c_en) mc = mc + 8'd1;
        qa_exp.push_back(ma);
        qs_exp.push_back(ms);
        qc_exp.push_back(mc);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare after each edge, away from it.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (qa_exp.size() > 0) begin
                automatic logic [3:0] ea = qa_exp.pop_front();
                automatic logic [3:0] es = qs_exp.pop_front();
                automatic logic [7:0] ec = qc_exp.pop_front();
                automatic string tg = tag_q.pop_front();
                check(q_a == ea, tg, "async slice count", q_a, ea);
                check(q_s == es, tg, "sync slice count", q_s, es);
                check({q_c1, q_c0} == ec, "R9", "chained count", {q_c1, q_c0}, ec);
            end
        end
    end

    initial begin
        #(HALF * 2 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog expired: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        step(0, 1, 0, 0, 4'd0, "R2 R3");
        step(0, 1, 1, 1, 4'd0, "R2 R3");
        c_en = 1'b1;
        step(1, 0, 0, 0, 4'd5, "R4");
        step(1, 1, 1, 1, 4'd0, "R5");
        step(1, 1, 1, 1, 4'd0, "R5");
        step(1, 1, 1, 1, 4'd0, "R5");
        step(1, 1, 0, 1, 4'd0, "R5");
        step(1, 1, 1, 0, 4'd0, "R5");
        step(1, 1, 0, 0, 4'd0, "R5");
        step(1, 0, 1, 1, 4'd14, "R4");
        step(1, 1, 1, 1, 4'd0, "R1");
        step(1, 1, 0, 0, 4'd0, "R6");
        step(1, 1, 0, 1, 4'd0, "R6");
        step(1, 0, 1, 1, 4'd9, "R4");
        step(1, 0, 1, 1, 4'd15, "R4");
        step(1, 1, 1, 1, 4'd0, "R1");
        step(1, 0, 0, 0, 4'd15, "R4");
        step(0, 0, 1, 1, 4'd7, "R3");
        step(1, 0, 0, 0, 4'd6, "R4");
        step(1, 1, 1, 1, 4'd0, "R5");
        step(0, 1, 1, 1, 4'd0, "R2 R3");
        for (int i = 0; i < 16; i++) begin
            step(i[3], i[2], i[1], i[0], 4'(i * 5 + 3), "R5");
            step(1, 0, 0, 1, 4'd15, "R4");
        end
        for (int i = 0; i < 280; i++) begin
            step(1, 1, 1, 1, 4'd0, "R1");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule